// File: doc/BRIEF.md
# Queued SPI Master (Mode 0, Single Target)

This block is a full-duplex SPI master that runs on a fast system clock. A host pushes bytes into a small transmit queue through a write-enable and data port. While the queue holds data the master pops bytes one at a time. It shifts each byte out on MOSI, most significant bit first, and shifts the MISO bits into a receive byte at the same time. When the eighth bit has been captured, the received byte appears on `rx_data` with a one-cycle `rx_valid` pulse.

The serial clock is made by the master alone. One SCK period lasts `2*DIV` system cycles. DIV is derived from two parameters, the system clock rate and the target device clock rate, as the smallest value that keeps SCK at or below one sixteenth of the target clock. The block uses mode 0: SCK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. A single active-low chip select surrounds each run of back-to-back bytes.

The sequencer has five states. **IDLE** (select high) moves to **LEAD** when the queue is not empty, and pops a byte as it does. **LEAD** (select low, SCK low) moves to **HIGH** after one half period. **HIGH** (SCK high, entered on a rising edge that samples MISO) moves after one half period to **LOW** if bits remain. After the last bit it moves to **LOW** with a freshly popped byte if the queue holds one, and to **TRAIL** otherwise. **LOW** moves to **HIGH** after one half period. **TRAIL** (select low, SCK low) returns to **IDLE** after one half period.

Top module: `spi_tx_master`

## Requirements
- R1: While reset is low and on the first cycle after it, spi_cs_n is 1, spi_sck is 0, spi_mosi is 0, fifo_full is 0 and rx_valid is 0.
- R2: A write is stored only when fifo_full is 0. fifo_full is 1 while FIFO_DEPTH bytes are queued. A write made while fifo_full is 1 is discarded, so that byte never appears on spi_mosi.
- R3: DIV equals ceil(8*SYS_CLK_HZ/TGT_CLK_HZ), which is 42 for the defaults 125 MHz and 24 MHz. Consecutive SCK rising edges within a run are 2*DIV system cycles apart. SCK is 0 whenever spi_cs_n is 1.
- R4: Each byte leaves on spi_mosi MSB first (bit 7 at the first rising edge). spi_mosi does not change on a rising edge of SCK or while SCK is high.
- R5: At each rising edge of SCK, the master samples spi_miso. The first sample becomes bit 7 of rx_data and the eighth becomes bit 0.
- R6: rx_valid is 1 for exactly one cycle, and that cycle is the one in which SCK shows its eighth rising edge of a byte. rx_data holds the completed byte in that cycle.
- R7: spi_cs_n falls DIV cycles before the first rising edge of a run. It rises DIV cycles after the last falling edge once the queue is empty.
- R8: If the queue is not empty when a byte ends, the next byte follows with spi_cs_n held low, and its first rising edge comes 2*DIV cycles after the previous byte's eighth rising edge.
- R9: Accepted bytes are sent in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host byte to queue |
| fifo_full | output | 1 | Queue full; writes are dropped |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse with a new rx_data |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | 1 | Active-low target select |

## Verification
Every serial output is registered from the next-state decode, so chip select, SCK, MOSI and rx_valid all change on the same clock edge as the state transition. The bench samples at the falling system edge and counts cycles between events. It expects the first rising edge DIV cycles after select falls, and later rising edges 2*DIV cycles apart, including across byte boundaries. It expects select to rise DIV cycles after the last falling edge, and rx_valid in exactly the cycle of the eighth rising edge. fifo_full is read at the falling edge before the write edge, because its value cannot change before that edge. The bench uses that reading to decide whether a write joins its expected byte stream.

// File: rtl/spi_m_pkg.sv
package spi_m_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } xfer_state_t;

    // Smallest half-period (system cycles) keeping SCK <= target/16.
    function automatic int unsigned half_period(input longint unsigned sys_hz,
                                                input longint unsigned tgt_hz);
        longint unsigned num;
        num = 64'd8 * sys_hz;
        return int'((num + tgt_hz - 64'd1) / tgt_hz);
    endfunction

endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam bit POW2  = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
    logic [CNT_W-1:0] count;
    logic             push, pull;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push    = wr_en && !full;
    assign pull    = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    generate
        if (POW2 || DEPTH == 1) begin : g_wrap_free
            assign wr_ptr_nx = (DEPTH == 1) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nx = (DEPTH == 1) ? '0 : rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr_nx;
            if (pull) rd_ptr <= rd_ptr_nx;
            unique case ({push, pull})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (count == CNT_W'(DEPTH)));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R9
    pull_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (rd_ptr == $past(rd_ptr)));

endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int HALF = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (HALF <= 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                     cnt <= '0;
                else if (!run)                  cnt <= '0;
                else if (cnt == CW'(HALF - 1))  cnt <= '0;
                else                            cnt <= cnt + 1'b1;
            end

            assign tick = run && (cnt == CW'(HALF - 1));

            // R3
            cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt <= CW'(HALF - 1));

            // R3
            idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> (cnt == '0));
        end
    endgenerate

endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
    import spi_m_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         q_empty,
    input  logic [W-1:0] q_data,
    input  logic         miso,
    output logic         q_pop,
    output logic         run,
    output logic         sck,
    output logic         cs_n,
    output logic         mosi,
    output logic [W-1:0] rx_data,
    output logic         rx_valid
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    xfer_state_t  state, state_d;
    logic [BW-1:0] bit_cnt;
    logic [W-1:0]  tx_sh, rx_sh;
    logic          last_bit, high_end, rise_now;

    assign last_bit = (bit_cnt == BW'(W - 1));
    assign high_end = (state == ST_HIGH) && tick;
    assign rise_now = (state_d == ST_HIGH) && (state != ST_HIGH);
    assign run      = (state != ST_IDLE);
    assign q_pop    = ((state == ST_IDLE) && !q_empty) ||
                      (high_end && last_bit && !q_empty);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (!q_empty) state_d = ST_LEAD;
            ST_LEAD:  if (tick)     state_d = ST_HIGH;
            ST_HIGH:  if (tick)     state_d = (last_bit && q_empty) ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick)     state_d = ST_HIGH;
            ST_TRAIL: if (tick)     state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck      <= 1'b0;
            cs_n     <= 1'b1;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            bit_cnt  <= '0;
        end else begin
            sck  <= (state_d == ST_HIGH);
            cs_n <= (state_d == ST_IDLE);

            if (q_pop)                      tx_sh <= q_data;
            else if (high_end && !last_bit) tx_sh <= tx_sh << 1;

            if (q_pop)         bit_cnt <= '0;
            else if (high_end) bit_cnt <= bit_cnt + 1'b1;

            rx_valid <= 1'b0;
            if (rise_now) begin
                rx_sh <= {rx_sh[W-2:0], miso};
                if (last_bit) begin
                    rx_data  <= {rx_sh[W-2:0], miso};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    assign mosi = tx_sh[W-1];

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R4
    mosi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));

    // R4
    mosi_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> (!sck || $stable(mosi)));

    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    rx_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $rose(sck));

    // R7
    cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sck);

    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ($past(state) == ST_TRAIL));

endmodule

// File: rtl/spi_tx_master.sv
module spi_tx_master
    import spi_m_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          FIFO_DEPTH = 4,
    parameter int unsigned SYS_CLK_HZ = 125_000_000,
    parameter int unsigned TGT_CLK_HZ = 24_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fifo_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int DIV = half_period(longint'(SYS_CLK_HZ), longint'(TGT_CLK_HZ));

    logic              q_empty, q_pop, run, tick;
    logic [DATA_W-1:0] q_data;

    spi_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (q_pop),
        .rd_data (q_data),
        .full    (fifo_full),
        .empty   (q_empty)
    );

    spi_half_tick #(.HALF(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_xfer_fsm #(.W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .q_empty  (q_empty),
        .q_data   (q_data),
        .miso     (spi_miso),
        .q_pop    (q_pop),
        .run      (run),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

endmodule

// File: tb/tb_spi_tx_master.sv
module tb_spi_tx_master;

    localparam int          DEPTH = 4;
    localparam int unsigned SYS   = 125_000_000;
    localparam int unsigned TGT   = 24_000_000;

    function automatic int exp_div();
        return int'((64'd8 * SYS + TGT - 1) / TGT);
    endfunction

    localparam int D = exp_div();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_full, rx_valid, spi_sck, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;
    logic [7:0] rx_data;

    always #4 clk = ~clk;

    spi_tx_master #(.DATA_W(8), .FIFO_DEPTH(DEPTH), .SYS_CLK_HZ(SYS), .TGT_CLK_HZ(TGT)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .rx_data(rx_data), .rx_valid(rx_valid),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    logic [7:0] exp_q[$];
    int         sent = 0, rx_cnt = 0, drops = 0;
    bit         full_seen = 0;

    // monitor and target model, all at the falling system edge
    bit         mon_on = 0;
    logic       p_sck = 0, p_cs = 1, p_mosi = 0;
    longint     cyc = 0, t_csf = 0, t_rise = 0, t_fall = 0;
    int         nbit = 0;
    bit         first_rise = 0;
    logic [7:0] m_byte = '0, s_byte = '0;

    function automatic logic [7:0] expect_pop();
        return exp_q.pop_front();
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            bit rise8;
            rise8 = 0;
            if (!spi_cs_n && p_cs) begin
                check(nbit == 0, "R7", nbit, 0);
                t_csf = cyc; first_rise = 1;
                s_byte = 8'($urandom); spi_miso = s_byte[7];
            end
            if (spi_cs_n && !p_cs) begin
                check(cyc - t_fall == D, "R7", int'(cyc - t_fall), D);
                check(nbit == 0, "R8", nbit, 0);
            end
            if (spi_sck && spi_cs_n) check(0, "R3", 1, 0);
            if (spi_sck && !p_sck) begin
                check(spi_mosi == p_mosi, "R4", spi_mosi, p_mosi);
                if (first_rise) check(cyc - t_csf == D, "R7", int'(cyc - t_csf), D);
                else            check(cyc - t_rise == 2*D, "R3 R8", int'(cyc - t_rise), 2*D);
                first_rise = 0; t_rise = cyc;
                m_byte = {m_byte[6:0], spi_mosi};
                nbit++;
                if (nbit == 8) begin
                    logic [7:0] e;
                    rise8 = 1; nbit = 0; sent++;
                    if (exp_q.size() == 0) check(0, "R2 R9", m_byte, 0);
                    else begin
                        e = expect_pop();
                        check(m_byte == e, "R4 R9", m_byte, e);
                    end
                    check(rx_valid == 1'b1, "R6", rx_valid, 1);
                    check(rx_data == s_byte, "R5", rx_data, s_byte);
                end
            end else if (spi_sck && p_sck) begin
                if (spi_mosi != p_mosi) check(0, "R4", spi_mosi, p_mosi);
            end
            if (!spi_sck && p_sck) begin
                t_fall = cyc;
                if (nbit == 0) s_byte = 8'($urandom);
                spi_miso = s_byte[7 - nbit];
            end
            if (rx_valid) rx_cnt++;
            if (rx_valid && !rise8) check(0, "R6", 1, 0);
            if (fifo_full) full_seen = 1;
        end
        p_sck = spi_sck; p_cs = spi_cs_n; p_mosi = spi_mosi;
    end

    task automatic host_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        if (!fifo_full) exp_q.push_back(b);
        else drops++;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || !spi_cs_n || nbit != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #1_520_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        check(D == 42, "R3", D, 42);
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        check(spi_cs_n && !spi_sck && !spi_mosi && !fifo_full && !rx_valid, "R1",
              {spi_cs_n, spi_sck, spi_mosi, fifo_full, rx_valid}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n && !spi_sck && !spi_mosi && !fifo_full && !rx_valid, "R1",
              {spi_cs_n, spi_sck, spi_mosi, fifo_full, rx_valid}, 5'b10000);
        mon_on = 1;

        // single byte
        host_write(8'hA5);
        wait_idle();

        // back-to-back extremes (R8)
        host_write(8'h00); host_write(8'hFF); host_write(8'h81);
        wait_idle();

        // overflow burst: extra writes must be dropped (R2)
        for (int i = 0; i < DEPTH + 4; i++) host_write(8'(8'h10 + i));
        check(full_seen, "R2", full_seen, 1);
        check(drops >= 2, "R2", drops, 2);
        wait_idle();
        check(!fifo_full, "R2", fifo_full, 0);

        // random traffic
        for (int k = 0; k < 30; k++) begin
            int n;
            n = 1 + int'($urandom_range(0, 3));
            for (int j = 0; j < n; j++) begin
                host_write(8'($urandom));
                repeat ($urandom_range(0, 3)) @(negedge clk);
            end
            if ($urandom_range(0, 1) == 1) wait_idle();
            else repeat ($urandom_range(50, 900)) @(negedge clk);
        end
        wait_idle();

        check(exp_q.size() == 0, "R9", exp_q.size(), 0);
        check(rx_cnt == sent, "R6", rx_cnt, sent);
        check(spi_cs_n && !spi_sck, "R3", {spi_cs_n, spi_sck}, 2'b10);
        finish_run();
    end

endmodule